// File: doc/BRIEF.md
# Branch Direction Predictor Table

This block guesses whether a conditional branch will be taken. It keeps a table of two-bit saturating counters and selects one counter with a slice of the fetch address. A lookup returns a taken or not-taken guess in the same cycle. When the branch later resolves, the counter it used is trained one step towards the real outcome.

A global enable selects where the guess comes from. With the enable high, the guess is the top bit of the counter. With it low, the guess is a static hint bit taken from the instruction word. The counters still train while the enable is low.

The block lets only one predicted branch be in flight. A second lookup that arrives while the first branch is still unresolved is stalled. A resolve in the same cycle releases the stall at once. Computing the target address, fetching instructions and flushing wrong-path work belong to other blocks.

Top module: `bp_direction_predictor`

## Requirements
- R1: After reset every counter holds weakly not-taken (2'b01), and no branch is outstanding. One taken resolve then makes that entry predict taken.
- R2: The entry is chosen by fetch address bits [10:2]. Addresses that differ only in bits [1:0] or above bit 10 share one counter.
- R3: With dynamic mode on, a granted lookup reports taken exactly when the selected counter's upper bit is 1 (states 2'b10 and 2'b11).
- R4: A taken resolve moves the addressed counter up by one and holds it at 2'b11.
- R5: A not-taken resolve moves the addressed counter down by one and holds it at 2'b00.
- R6: With dynamic mode off, a granted lookup reports the instruction hint bit and ignores the counter. With dynamic mode on, the hint bit has no effect.
- R7: Resolves train the counters whatever the state of the dynamic-mode enable.
- R8: A granted lookup marks one branch outstanding. A later lookup without a resolve in that cycle raises `stall`. While stalled, `pred_valid` and `pred_taken` are 0.
- R9: A resolve clears the outstanding mark, and it grants a lookup presented in the same cycle.
- R10: A lookup and a resolve that hit the same entry in one cycle return the counter value from before the update. The update takes effect at the clock edge.
- R11: `stall` and `pred_valid` are 0 in any cycle without a lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dyn_en | input | 1 | 1 selects the counter guess, 0 selects the static hint |
| lk_valid | input | 1 | A conditional branch asks for a guess |
| lk_pc | input | ADDR_W | Fetch address of the branch being looked up |
| lk_hint | input | 1 | Static direction hint from the instruction word |
| rs_valid | input | 1 | A branch outcome is known |
| rs_pc | input | ADDR_W | Fetch address of the resolved branch |
| rs_taken | input | 1 | Outcome of the resolved branch |
| pred_valid | output | 1 | Lookup granted this cycle |
| pred_taken | output | 1 | Guess for the granted lookup (0 when not granted) |
| stall | output | 1 | Lookup held back by an outstanding branch |

## Verification
Runs of taken and not-taken outcomes walk one counter from weakly not-taken up into strongly taken and back down to strongly not-taken. These runs show both saturation limits and the threshold where the guess flips. The same-cycle lookup-and-resolve pattern on one entry separates read-before-write from write-through. Address pairs that differ inside and outside bits [10:2] separate correct indexing from aliasing and from slices shifted by a bit. Toggling the enable while training, with hint bits set against the counter, shows that the guess source and the training path are independent, and back-to-back lookups with and without a resolve cover stall entry and same-cycle release.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    typedef struct packed {
        logic busy;
    } trk_state_t;

    // Saturating one-step move of a two-bit counter towards the outcome.
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        nxt = cur;
        if (taken) begin
            if (cur != 2'(CTR_STRONG_T)) nxt = cur + 2'd1;
        end else begin
            if (cur != 2'(CTR_STRONG_NT)) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bp_counter_table.sv
module bp_counter_table
    import bp_pkg::*;
#(
    parameter int ENTRIES = 512,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    logic [1:0] tbl_q [ENTRIES];
    logic [1:0] tbl_d [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            tbl_d[i] = tbl_q[i];
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                tbl_d[i] = ctr_step(tbl_q[i], wr_taken);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= 2'(CTR_WEAK_NT);
        end else begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= tbl_d[i];
        end
    end

    // Read returns the registered value: a same-cycle write is not forwarded.
    assign rd_ctr = tbl_q[rd_idx];

    // R4: saturation at the top
    a_r4_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken && (tbl_q[wr_idx] == 2'b11) |=> tbl_q[$past(wr_idx)] == 2'b11);
    // R4: a taken update never lowers the counter
    a_r4_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken |=> tbl_q[$past(wr_idx)] >= $past(tbl_q[wr_idx]));
    // R5: saturation at the bottom
    a_r5_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && (tbl_q[wr_idx] == 2'b00) |=> tbl_q[$past(wr_idx)] == 2'b00);
    // R5: a not-taken update never raises the counter
    a_r5_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken |=> tbl_q[$past(wr_idx)] <= $past(tbl_q[wr_idx]));

endmodule

// File: rtl/bp_inflight_tracker.sv
module bp_inflight_tracker
    import bp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic release_i,
    output logic grant,
    output logic stall,
    output logic busy
);

    trk_state_t st_q, st_d;

    always_comb begin
        stall     = req && st_q.busy && !release_i;
        grant     = req && !stall;
        st_d      = st_q;
        st_d.busy = (st_q.busy && !release_i) || grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;

    // R8: a stall needs an outstanding branch
    a_r8_stall_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> busy);
    // R8: a granted lookup leaves a branch outstanding
    a_r8_grant_marks: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> busy);
    // R9: a resolve always lets a waiting lookup through
    a_r9_release_grants: assert property (@(posedge clk) disable iff (!rst_n)
        req && release_i |-> grant);
    // R9: a resolve with no new lookup empties the tracker
    a_r9_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        release_i && !req |=> !busy);

endmodule

// File: rtl/bp_direction_predictor.sv
module bp_direction_predictor
    import bp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ENTRIES  = 512,
    parameter int IDX_LSB  = 2,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int IDX_MSB = IDX_LSB + IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dyn_en,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic              lk_hint,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_pc,
    input  logic              rs_taken,
    output logic              pred_valid,
    output logic              pred_taken,
    output logic              stall
);

    logic [IDX_W-1:0] lk_idx, rs_idx;
    logic [1:0]       lk_ctr;
    logic             grant, trk_busy, guess;
    logic             unused_pc_bits;

    assign lk_idx = lk_pc[IDX_MSB:IDX_LSB];
    assign rs_idx = rs_pc[IDX_MSB:IDX_LSB];
    assign unused_pc_bits = ^{lk_pc[ADDR_W-1:IDX_MSB+1], lk_pc[IDX_LSB-1:0],
                              rs_pc[ADDR_W-1:IDX_MSB+1], rs_pc[IDX_LSB-1:0], trk_busy};

    bp_counter_table #(.ENTRIES(ENTRIES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (rs_valid),
        .wr_idx   (rs_idx),
        .wr_taken (rs_taken)
    );

    bp_inflight_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (lk_valid),
        .release_i (rs_valid),
        .grant     (grant),
        .stall     (stall),
        .busy      (trk_busy)
    );

    always_comb begin
        guess      = dyn_en ? lk_ctr[1] : lk_hint;
        pred_valid = grant;
        pred_taken = grant && guess;
    end

    // R8: granted and stalled are exclusive
    a_r8_valid_xor_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(pred_valid && stall));
    // R11: no lookup, no output activity
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !pred_valid && !stall);
    // R6: static mode follows the hint
    a_r6_static_hint: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid && !dyn_en |-> pred_taken == lk_hint);
    // R3: a taken guess only ever comes with a grant
    a_r3_taken_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_valid);

endmodule

// File: tb/tb_bp_direction_predictor.sv
module tb_bp_direction_predictor;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 32;

    typedef struct packed {
        logic        dyn;
        logic        lkv;
        logic [11:0] lkpc;
        logic        hint;
        logic        rsv;
        logic [11:0] rspc;
        logic        rtk;
        logic        ev;
        logic        et;
        logic        es;
        logic [3:0]  req;
    } vec_t;

    // Rows: dyn lkv lkpc hint rsv rspc rtk | exp valid taken stall | requirement
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,12'h000,1'b0,1'b0,12'h000,1'b0, 1'b0,1'b0,1'b0, 4'd11}, // R11 idle
        '{1'b1,1'b1,12'h100,1'b1,1'b0,12'h000,1'b0, 1'b1,1'b0,1'b0, 4'd1 }, // R1 weak NT
        '{1'b1,1'b1,12'h104,1'b0,1'b0,12'h000,1'b0, 1'b0,1'b0,1'b1, 4'd8 }, // R8 second stalls
        '{1'b1,1'b1,12'h104,1'b0,1'b1,12'h100,1'b1, 1'b1,1'b0,1'b0, 4'd9 }, // R9 same-cycle release
        '{1'b1,1'b0,12'h000,1'b0,1'b1,12'h104,1'b0, 1'b0,1'b0,1'b0, 4'd5 }, // R5 B 1->0
        '{1'b1,1'b1,12'h100,1'b0,1'b0,12'h000,1'b0, 1'b1,1'b1,1'b0, 4'd3 }, // R3 A=2 taken
        '{1'b1,1'b0,12'h000,1'b0,1'b1,12'h100,1'b1, 1'b0,1'b0,1'b0, 4'd4 }, // R4 A->3
        '{1'b1,1'b0,12'h000,1'b0,1'b1,12'h100,1'b1, 1'b0,1'b0,1'b0, 4'd4 }, // R4 A stays 3
        '{1'b1,1'b1,12'h100,1'b0,1'b0,12'h000,1'b0, 1'b1,1'b1,1'b0, 4'd4 }, // R4 A=3
        '{1'b1,1'b1,12'h100,1'b0,1'b1,12'h100,1'b0, 1'b1,1'b1,1'b0, 4'd10}, // R10 old 3
        '{1'b1,1'b1,12'h100,1'b0,1'b1,12'h100,1'b0, 1'b1,1'b1,1'b0, 4'd5 }, // R5 old 2
        '{1'b1,1'b1,12'h100,1'b0,1'b1,12'h100,1'b0, 1'b1,1'b0,1'b0, 4'd5 }, // R5 old 1
        '{1'b1,1'b1,12'h100,1'b0,1'b1,12'h100,1'b0, 1'b1,1'b0,1'b0, 4'd5 }, // R5 old 0 stays
        '{1'b1,1'b1,12'h100,1'b0,1'b1,12'h100,1'b1, 1'b1,1'b0,1'b0, 4'd10}, // R10 old 0, ->1
        '{1'b1,1'b0,12'h000,1'b0,1'b1,12'h100,1'b1, 1'b0,1'b0,1'b0, 4'd4 }, // R4 A->2
        '{1'b0,1'b1,12'h100,1'b0,1'b0,12'h000,1'b0, 1'b1,1'b0,1'b0, 4'd6 }, // R6 hint 0 over ctr 2
        '{1'b0,1'b1,12'h104,1'b1,1'b1,12'h100,1'b0, 1'b1,1'b1,1'b0, 4'd6 }, // R6 hint 1 over ctr 0
        '{1'b0,1'b0,12'h000,1'b0,1'b1,12'h104,1'b1, 1'b0,1'b0,1'b0, 4'd7 }, // R7 B->1
        '{1'b0,1'b0,12'h000,1'b0,1'b1,12'h104,1'b1, 1'b0,1'b0,1'b0, 4'd7 }, // R7 B->2
        '{1'b1,1'b1,12'h100,1'b0,1'b0,12'h000,1'b0, 1'b1,1'b0,1'b0, 4'd7 }, // R7 A trained to 1
        '{1'b1,1'b1,12'h104,1'b0,1'b1,12'h100,1'b1, 1'b1,1'b1,1'b0, 4'd7 }, // R7 B trained to 2
        '{1'b1,1'b0,12'h000,1'b0,1'b1,12'h104,1'b1, 1'b0,1'b0,1'b0, 4'd4 }, // R4 B->3
        '{1'b1,1'b1,12'h103,1'b0,1'b0,12'h000,1'b0, 1'b1,1'b1,1'b0, 4'd2 }, // R2 low bits alias
        '{1'b1,1'b0,12'h000,1'b0,1'b1,12'h900,1'b0, 1'b0,1'b0,1'b0, 4'd2 }, // R2 high bits alias
        '{1'b1,1'b1,12'h100,1'b1,1'b0,12'h000,1'b0, 1'b1,1'b0,1'b0, 4'd2 }, // R2 A=1, hint ignored
        '{1'b1,1'b0,12'h000,1'b0,1'b1,12'h100,1'b0, 1'b0,1'b0,1'b0, 4'd5 }, // R5 A->0
        '{1'b1,1'b1,12'h904,1'b0,1'b0,12'h000,1'b0, 1'b1,1'b1,1'b0, 4'd2 }, // R2 B via alias
        '{1'b1,1'b0,12'h000,1'b0,1'b1,12'h104,1'b1, 1'b0,1'b0,1'b0, 4'd4 }, // R4 B stays 3
        '{1'b0,1'b1,12'h100,1'b1,1'b0,12'h000,1'b0, 1'b1,1'b1,1'b0, 4'd6 }, // R6 static grant
        '{1'b0,1'b1,12'h100,1'b1,1'b0,12'h000,1'b0, 1'b0,1'b0,1'b1, 4'd8 }, // R8 static stall
        '{1'b0,1'b0,12'h000,1'b0,1'b1,12'h100,1'b0, 1'b0,1'b0,1'b0, 4'd9 }, // R9 release
        '{1'b1,1'b0,12'h000,1'b0,1'b0,12'h000,1'b0, 1'b0,1'b0,1'b0, 4'd11}  // R11 idle
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dyn_en = 1'b0, lk_valid = 1'b0, lk_hint = 1'b0;
    logic        rs_valid = 1'b0, rs_taken = 1'b0;
    logic [31:0] lk_pc = '0, rs_pc = '0;
    logic        pred_valid, pred_taken, stall;
    int          n_checks = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_direction_predictor dut (
        .clk(clk), .rst_n(rst_n), .dyn_en(dyn_en),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hint(lk_hint),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
        .pred_valid(pred_valid), .pred_taken(pred_taken), .stall(stall)
    );

    task automatic drive(input logic d, input logic lv, input logic [11:0] lp, input logic h,
                         input logic rv, input logic [11:0] rp, input logic rt);
        @(negedge clk);
        dyn_en = d; lk_valid = lv; lk_pc = {20'd0, lp}; lk_hint = h;
        rs_valid = rv; rs_pc = {20'd0, rp}; rs_taken = rt;
        #1;
    endtask

    task automatic check(input int req, input logic ev, input logic et, input logic es);
        n_checks++;
        if ({pred_valid, pred_taken, stall} !== {ev, et, es}) begin
            n_fail++;
            $display("FAIL R%0d: valid/taken/stall = %b%b%b, expected %b%b%b",
                     req, pred_valid, pred_taken, stall, ev, et, es);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // Reset state: quiet outputs (R11)
        #1 check(11, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].dyn, VEC[i].lkv, VEC[i].lkpc, VEC[i].hint,
                  VEC[i].rsv, VEC[i].rspc, VEC[i].rtk);
            check(int'(VEC[i].req), VEC[i].ev, VEC[i].et, VEC[i].es);
        end

        // Leave a branch outstanding, then reset mid-run (R1)
        drive(1'b1, 1'b1, 12'h104, 1'b0, 1'b0, 12'h000, 1'b0);
        check(3, 1'b1, 1'b1, 1'b0);
        drive(1'b0, 1'b0, 12'h000, 1'b0, 1'b0, 12'h000, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: counter B back to weak NT and nothing outstanding
        drive(1'b1, 1'b1, 12'h104, 1'b0, 1'b0, 12'h000, 1'b0);
        check(1, 1'b1, 1'b0, 1'b0);
        // R1: one taken resolve on top entry (index 511) flips it to taken
        drive(1'b1, 1'b0, 12'h000, 1'b0, 1'b1, 12'h7FC, 1'b1);
        check(11, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 12'h7FC, 1'b0, 1'b0, 12'h000, 1'b0);
        check(2, 1'b1, 1'b1, 1'b0);
        // R2: index 0 untouched by training of index 511
        drive(1'b1, 1'b1, 12'h000, 1'b0, 1'b1, 12'h7FC, 1'b1);
        check(2, 1'b1, 1'b0, 1'b0);
        // R11: resolve only, stall stays low
        drive(1'b1, 1'b0, 12'h000, 1'b0, 1'b1, 12'h000, 1'b0);
        check(11, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule